// File: doc/BRIEF.md
# I2C Tuning Synthesiser Control Port

This block is the serial control front end of a frequency synthesiser. It watches an I2C bus through plain SCL and SDA inputs, answers one of four slave addresses chosen by two select pins, and loads the divide word and the loop, reference-output and port settings from the bytes it is sent. It drives SDA only by pulling it low, so an external pull-up and other bus agents can share the line. A write transaction carries pairs of data bytes. The top bit of the first byte in each pair says whether the pair holds frequency data or control data.

The 17-bit divide word is built in staging registers and reaches the synthesiser in one step. This happens either when all three bytes that carry divide bits have arrived, or when a stop ends a write that staged frequency bits. Control fields take effect as soon as their byte arrives. A read transaction returns a status byte made from the power-on flag, the lock flag and a 3-bit level code. A stop that ends a read gives a one-cycle pulse that tells the owner of the power-on flag to clear it.

Top module: `tsyn_ctrl_port`

## Requirements
- R1: The slave acknowledges only an address byte whose upper five bits are 11000 and whose next two bits equal `addr_sel_i`. Bit 0 is 0 for a write and 1 for a read. Any other address is not acknowledged and leaves all outputs unchanged.
- R2: In a write transaction, every complete data byte is acknowledged by pulling SDA low during the ninth clock.
- R3: The first data byte of each pair is a frequency-high byte when its MSB is 0 (bits 6..0 give divide bits 14..8). It is control byte A when its MSB is 1: bits 6..5 give divide bits 16..15, bit 4 the prescaler enable and bits 3..0 the reference code. The byte after it is frequency-low (divide bits 7..0) or control byte B. Pairs repeat until a stop or a new address.
- R4: When frequency-high, frequency-low and control A have all been received since the last update, `div_o` takes the staged word one cycle after the completing byte, with no stop needed.
- R5: A stop after a write that staged any divide bits copies the staged word to `div_o`. Frequency-high and frequency-low bytes sent repeatedly without a stop leave `div_o` unchanged.
- R6: A stop in the middle of a byte throws away the partial byte. All staged and active data stay as they were before that byte.
- R7: Control B loads bits 7..6 into `cp_cur_o`, bit 5 into `ref_out_en_o`, bit 4 into `out_sel_o` and bit 3 into `port_o[3]`. After reset, `ref_out_en_o` and `out_sel_o` are 1 and every other register output is 0.
- R8: When control B has bit 5 = 0 and bit 4 = 1 (test mode), its bits 2..0 go to `test_sel_o` and `port_o[2:0]` keeps its value. Otherwise bits 2..0 go to `port_o[2:0]` and `test_sel_o` keeps its value.
- R9: A read returns {`por_flag_i`, `lock_i`, 0, 0, 0, `level_i`}, MSB first. The byte is sampled again for each further byte that the master acknowledges.
- R10: If the master does not acknowledge a status byte, the slave releases SDA and drives nothing until the next start.
- R11: `por_clr_o` pulses for one cycle at a stop that ends a transaction whose address was a matching read. A stop after a write gives no pulse.
- R12: `sda_oe_o` high means SDA is pulled low. It is low after reset and in the cycle after any stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 2 | Selects one of the four slave addresses |
| por_flag_i | input | 1 | Power-on flag for the status byte |
| lock_i | input | 1 | Phase lock flag for the status byte |
| level_i | input | 3 | Level code for the status byte |
| por_clr_o | output | 1 | One-cycle request to clear the power-on flag |
| div_o | output | 17 | Active divide word |
| pe_o | output | 1 | Prescaler enable |
| ref_code_o | output | 4 | Reference divider code |
| cp_cur_o | output | 2 | Charge-pump current select |
| ref_out_en_o | output | 1 | Reference/comparison output enable |
| out_sel_o | output | 1 | Output select, or test enable when the output is off |
| test_sel_o | output | 3 | Test-mode select |
| port_o | output | 4 | Switching port states |

## Verification
Two things can happen on the same byte. When control A arrives after both frequency bytes, it updates the prescaler and reference fields and also completes the 17-bit word. The bench provokes this with the byte orders high-low-A-B and A-B-high-low. After the completing byte and before any stop, it checks that the divide word and the control fields have both moved to their new values, and that neither moved one byte earlier. In the same way, a stop that cuts a byte short must throw away the partial byte and still commit the pending word. The bench judges this by checking that the new high bits appear on `div_o` while the low bits and the control fields keep their old values.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;
  localparam int DIV_W = 17;
  localparam logic [4:0] ADDR_FIXED = 5'b11000;

  typedef enum logic [2:0] {
    L_IDLE,
    L_ADDR,
    L_WBYTE,
    L_ACKW,
    L_ACKD,
    L_RBYTE,
    L_RACK,
    L_RRLD
  } link_st_t;
endpackage

// File: rtl/tsyn_bus_sync.sv
module tsyn_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tsyn_link.sv
module tsyn_link
  import tsyn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic       sda_s,
  input  logic [1:0] ma,
  input  logic [7:0] status,
  output logic       sda_oe,
  output logic       byte_v,
  output logic [7:0] byte_d,
  output logic       wr_addr_p,
  output logic       por_clr_p
);
  link_st_t   st_q, st_n;
  logic [2:0] bit_q, bit_n;
  logic [7:0] sh_q, sh_n, bd_q, bd_n;
  logic       rw_q, rw_n, rds_q, rds_n, oe_q, oe_n;
  logic       bv_q, bv_n, wa_q, wa_n, pc_q, pc_n;

  always_comb begin
    st_n = st_q;  bit_n = bit_q; sh_n = sh_q; bd_n = bd_q;
    rw_n = rw_q;  rds_n = rds_q; oe_n = oe_q;
    bv_n = 1'b0;  wa_n = 1'b0;   pc_n = 1'b0;
    if (stop_p) begin
      st_n = L_IDLE; oe_n = 1'b0; pc_n = rds_q; rds_n = 1'b0;
    end else if (start_p) begin
      st_n = L_ADDR; bit_n = '0; oe_n = 1'b0; rds_n = 1'b0;
    end else begin
      case (st_q)
        L_ADDR: if (scl_rise) begin
          sh_n  = {sh_q[6:0], sda_s};
          bit_n = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            if (sh_q[6:2] == ADDR_FIXED && sh_q[1:0] == ma) begin
              rw_n  = sda_s;
              rds_n = sda_s;
              wa_n  = ~sda_s;
              st_n  = L_ACKW;
            end else begin
              st_n = L_IDLE;
            end
          end
        end
        L_WBYTE: if (scl_rise) begin
          sh_n  = {sh_q[6:0], sda_s};
          bit_n = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            bv_n = 1'b1;
            bd_n = {sh_q[6:0], sda_s};
            st_n = L_ACKW;
          end
        end
        L_ACKW: if (scl_fall) begin
          oe_n = 1'b1; st_n = L_ACKD;
        end
        L_ACKD: if (scl_fall) begin
          bit_n = '0;
          if (rw_q) begin
            sh_n = {status[6:0], 1'b0}; oe_n = ~status[7]; st_n = L_RBYTE;
          end else begin
            oe_n = 1'b0; st_n = L_WBYTE;
          end
        end
        L_RBYTE: if (scl_fall) begin
          if (bit_q == 3'd7) begin
            oe_n = 1'b0; st_n = L_RACK;
          end else begin
            bit_n = bit_q + 3'd1;
            oe_n  = ~sh_q[7];
            sh_n  = {sh_q[6:0], 1'b0};
          end
        end
        L_RACK: if (scl_rise) st_n = sda_s ? L_IDLE : L_RRLD;
        L_RRLD: if (scl_fall) begin
          bit_n = '0; sh_n = {status[6:0], 1'b0}; oe_n = ~status[7]; st_n = L_RBYTE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= L_IDLE; bit_q <= '0; sh_q <= '0; bd_q <= '0;
      rw_q <= 1'b0; rds_q <= 1'b0; oe_q <= 1'b0;
      bv_q <= 1'b0; wa_q <= 1'b0; pc_q <= 1'b0;
    end else begin
      st_q <= st_n; bit_q <= bit_n; sh_q <= sh_n; bd_q <= bd_n;
      rw_q <= rw_n; rds_q <= rds_n; oe_q <= oe_n;
      bv_q <= bv_n; wa_q <= wa_n; pc_q <= pc_n;
    end
  end

  assign sda_oe    = oe_q;
  assign byte_v    = bv_q;
  assign byte_d    = bd_q;
  assign wr_addr_p = wa_q;
  assign por_clr_p = pc_q;

  // R12: a stop always frees the line in the following cycle
  assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !oe_q);
  // R10: a high SDA in the master acknowledge slot ends the read
  assert_nack_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_RACK && scl_rise && sda_s && !stop_p && !start_p) |=> (!oe_q && st_q == L_IDLE));
  // R2: data bytes are reported only for write transactions
  assert_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> !rw_q);
endmodule

// File: rtl/tsyn_regs.sv
module tsyn_regs
  import tsyn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_v,
  input  logic [7:0]       byte_d,
  input  logic             wr_addr_p,
  input  logic             stop_p,
  output logic [DIV_W-1:0] div,
  output logic             pe,
  output logic [3:0]       ref_code,
  output logic [1:0]       cp_cur,
  output logic             re,
  output logic             rts,
  output logic [2:0]       test_sel,
  output logic [3:0]       port
);
  logic             second_q, second_n, kind_q, kind_n, pend_q, pend_n;
  logic [6:0]       hi_q, hi_n;
  logic [7:0]       lo_q, lo_n;
  logic [1:0]       top_q, top_n, cp_q, cp_n;
  logic [2:0]       got_q, got_n, ts_q, ts_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic             pe_q, pe_n, re_q, re_n, rts_q, rts_n;
  logic [3:0]       ref_q, ref_n, port_q, port_n;

  always_comb begin
    second_n = second_q; kind_n = kind_q; pend_n = pend_q;
    hi_n = hi_q; lo_n = lo_q; top_n = top_q; got_n = got_q; div_n = div_q;
    pe_n = pe_q; ref_n = ref_q; cp_n = cp_q; re_n = re_q; rts_n = rts_q;
    ts_n = ts_q; port_n = port_q;
    if (wr_addr_p) second_n = 1'b0;
    if (byte_v) begin
      if (!second_q) begin
        kind_n = byte_d[7]; second_n = 1'b1; pend_n = 1'b1;
        if (!byte_d[7]) begin
          hi_n = byte_d[6:0]; got_n[0] = 1'b1;
        end else begin
          top_n = byte_d[6:5]; pe_n = byte_d[4]; ref_n = byte_d[3:0]; got_n[2] = 1'b1;
        end
      end else begin
        second_n = 1'b0;
        if (!kind_q) begin
          lo_n = byte_d; got_n[1] = 1'b1; pend_n = 1'b1;
        end else begin
          cp_n = byte_d[7:6]; re_n = byte_d[5]; rts_n = byte_d[4];
          port_n[3] = byte_d[3];
          if (byte_d[5:4] == 2'b01) ts_n = byte_d[2:0];
          else                      port_n[2:0] = byte_d[2:0];
        end
      end
    end
    if ((stop_p && pend_q) || (byte_v && (&got_n))) begin
      div_n  = {top_n, hi_n, lo_n};
      got_n  = '0;
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0; kind_q <= 1'b0; pend_q <= 1'b0;
      hi_q <= '0; lo_q <= '0; top_q <= '0; got_q <= '0; div_q <= '0;
      pe_q <= 1'b0; ref_q <= '0; cp_q <= '0; re_q <= 1'b1; rts_q <= 1'b1;
      ts_q <= '0; port_q <= '0;
    end else begin
      second_q <= second_n; kind_q <= kind_n; pend_q <= pend_n;
      hi_q <= hi_n; lo_q <= lo_n; top_q <= top_n; got_q <= got_n; div_q <= div_n;
      pe_q <= pe_n; ref_q <= ref_n; cp_q <= cp_n; re_q <= re_n; rts_q <= rts_n;
      ts_q <= ts_n; port_q <= port_n;
    end
  end

  assign div = div_q;   assign pe = pe_q;     assign ref_code = ref_q;
  assign cp_cur = cp_q; assign re = re_q;     assign rts = rts_q;
  assign test_sel = ts_q; assign port = port_q;

  // R5: without a byte or a stop the active word cannot move
  assert_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_v && !stop_p) |=> $stable(div_q));
  // R8: a test-mode control B leaves the low port bits alone
  assert_test_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_v && second_q && kind_q && byte_d[5:4] == 2'b01) |=> $stable(port_q[2:0]));
  // R3: the first byte of a pair always opens the second half
  assert_pair_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_v && !second_q && !wr_addr_p) |=> second_q);
endmodule

// File: rtl/tsyn_ctrl_port.sv
module tsyn_ctrl_port
  import tsyn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [1:0]       addr_sel_i,
  input  logic             por_flag_i,
  input  logic             lock_i,
  input  logic [2:0]       level_i,
  output logic             por_clr_o,
  output logic [DIV_W-1:0] div_o,
  output logic             pe_o,
  output logic [3:0]       ref_code_o,
  output logic [1:0]       cp_cur_o,
  output logic             ref_out_en_o,
  output logic             out_sel_o,
  output logic [2:0]       test_sel_o,
  output logic [3:0]       port_o
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic       sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic       byte_v, wr_addr_p;
  logic [7:0] byte_d, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  assign status = {por_flag_i, lock_i, 3'b000, level_i};

  tsyn_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  tsyn_link u_link (
    .clk(clk), .rst_n(rst_sn), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .sda_s(sda_s), .ma(addr_sel_i),
    .status(status), .sda_oe(sda_oe_o), .byte_v(byte_v), .byte_d(byte_d),
    .wr_addr_p(wr_addr_p), .por_clr_p(por_clr_o)
  );

  tsyn_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .byte_v(byte_v), .byte_d(byte_d),
    .wr_addr_p(wr_addr_p), .stop_p(stop_p), .div(div_o), .pe(pe_o),
    .ref_code(ref_code_o), .cp_cur(cp_cur_o), .re(ref_out_en_o),
    .rts(out_sel_o), .test_sel(test_sel_o), .port(port_o)
  );
endmodule

// File: tb/sim_tsyn_ctrl_port.sv
`timescale 1ns/1ps
module sim_tsyn_ctrl_port;
  logic        clk = 1'b0;
  logic        rst_n, scl, sda_m;
  logic [1:0]  addr_sel;
  logic        por_f, lock;
  logic [2:0]  level;
  wire         sda_oe, por_clr, pe, re, rts;
  wire  [16:0] div;
  wire  [3:0]  ref_code, port;
  wire  [1:0]  cp;
  wire  [2:0]  ts;
  wire         sda_bus = sda_m & ~sda_oe;

  int checks = 0, fails = 0, por_cnt = 0;
  bit done = 0;
  logic ack;
  logic [7:0] rd;
  logic [16:0] cur;

  always #4 clk = ~clk;

  tsyn_ctrl_port u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .por_flag_i(por_f), .lock_i(lock), .level_i(level),
    .por_clr_o(por_clr), .div_o(div), .pe_o(pe), .ref_code_o(ref_code),
    .cp_cur_o(cp), .ref_out_en_o(re), .out_sel_o(rts), .test_sel_o(ts), .port_o(port)
  );

  always @(posedge clk) if (por_clr) por_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; q(); scl = 1'b1; q(); b = sda_bus; q(); scl = 1'b0; q();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic a);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(mack);
  endtask

  task automatic wr(input logic [7:0] d);
    logic a;
    wbyte(d, a);
    chk("R2 data ack", a, 0);
  endtask

  function automatic logic [7:0] b_hi(input logic [16:0] w); return {1'b0, w[14:8]}; endfunction
  function automatic logic [7:0] b_lo(input logic [16:0] w); return w[7:0]; endfunction
  function automatic logic [7:0] b_a(input logic [16:0] w, input logic p, input logic [3:0] r);
    return {1'b1, w[16:15], p, r};
  endfunction

  localparam logic [7:0] WADDR = 8'hC4;
  localparam logic [7:0] RADDR = 8'hC5;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; addr_sel = 2'b10;
    por_f = 1'b1; lock = 1'b0; level = 3'b000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7 and R12: reset values
    chk("R7 reset div", div, 0);
    chk("R7 reset ctrl", {pe, ref_code, cp, ts, port}, 0);
    chk("R7 reset re/rts", {re, rts}, 2'b11);
    chk("R12 reset oe", sda_oe, 0);

    // R1: sweep of select pins against address bits
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 4; a++) begin
        addr_sel = 2'(m);
        bus_start();
        wbyte({5'b11000, 2'(a), 1'b0}, ack);
        chk("R1 address match", ack, (a == m) ? 0 : 1);
        bus_stop();
      end
    end
    addr_sel = 2'b10;
    bus_start(); wbyte(8'hA4, ack); chk("R1 fixed bits", ack, 1); bus_stop();
    chk("R1 no effect", div, 0);

    // R4/R7: order high, low, A, B over a sweep of words
    cur = '0;
    for (int k = 0; k < 6; k++) begin
      logic [16:0] w;
      w = 17'(k * 17'h12345 + 17'h003C1);
      bus_start(); wr(WADDR);
      wr(b_hi(w)); wr(b_lo(w));
      chk("R5 no commit after low", div, cur);
      wr(b_a(w, k[0], 4'(k + 3)));
      chk("R4 commit on A", div, w);
      chk("R7 pe/ref", {pe, ref_code}, {k[0], 4'(k + 3)});
      wr({2'(k), 1'b1, 1'b0, 4'(k * 5)});
      bus_stop();
      chk("R7 control B", {cp, re, rts, port}, {2'(k), 1'b1, 1'b0, 4'(k * 5)});
      cur = w;
    end
    chk("R11 no pulse on write", por_cnt, 0);

    // R3/R4: order A, B, high, low
    begin
      logic [16:0] w2;
      w2 = 17'h15A5A;
      bus_start(); wr(WADDR);
      wr(b_a(w2, 1'b1, 4'h9)); wr(8'hFA);
      chk("R3 control pair no commit", div, cur);
      chk("R3 control B fields", {cp, re, rts, port}, 8'hFA);
      wr(b_hi(w2)); wr(b_lo(w2));
      chk("R4 commit on low", div, w2);
      bus_stop();
      cur = w2;
    end

    // R5: repeated high/low with no stop, then stop
    bus_start(); wr(WADDR);
    wr(8'h12); wr(8'h34); wr(8'h56); wr(8'h78);
    chk("R5 repeat no change", div, cur);
    bus_stop();
    cur = {cur[16:15], 7'h56, 8'h78};
    chk("R5 stop commits", div, cur);

    bus_start(); wr(WADDR); wr(8'h55); bus_stop();
    cur = {cur[16:15], 7'h55, cur[7:0]};
    chk("R5 high then stop", div, cur);

    bus_start(); wr(WADDR); wr(8'hA3); bus_stop();
    cur = {2'b01, cur[14:0]};
    chk("R5 A then stop", div, cur);
    chk("R7 A fields", {pe, ref_code}, {1'b0, 4'h3});

    // R6: stop inside the byte after a frequency-high byte
    bus_start(); wr(WADDR); wr(8'h2A);
    wbit(1'b1); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bus_stop();
    cur = {cur[16:15], 7'h2A, cur[7:0]};
    chk("R6 partial discarded", div, cur);
    chk("R6 control kept", {pe, ref_code}, {1'b0, 4'h3});

    // R8: test mode keeps low port bits (port is now 4'hA)
    bus_start(); wr(WADDR);
    wr(b_a(cur, 1'b1, 4'h5)); wr(8'b0001_0110);
    chk("R8 test select", ts, 3'b110);
    chk("R8 port hold", port, 4'h2);
    chk("R8 mode bits", {re, rts}, 2'b01);
    wr(b_a(cur, 1'b1, 4'h5)); wr(8'b0000_1001);
    chk("R8 normal port", port, 4'h9);
    chk("R8 select kept", ts, 3'b110);
    bus_stop();
    chk("R12 oe after stop", sda_oe, 0);

    // R9..R11: read, reload on master ack, release on nack
    por_f = 1'b1; lock = 1'b1; level = 3'b101;
    bus_start(); wbyte(RADDR, ack);
    chk("R1 read address ack", ack, 0);
    level = 3'b000;
    rbyte(1'b0, rd); chk("R9 first status", rd, 8'hC5);
    rbyte(1'b1, rd); chk("R9 resampled status", rd, 8'hC0);
    rbyte(1'b1, rd); chk("R10 released after nack", rd, 8'hFF);
    chk("R10 oe low", sda_oe, 0);
    chk("R11 no pulse before stop", por_cnt, 0);
    bus_stop();
    chk("R11 pulse on read stop", por_cnt, 1);
    chk("R12 oe idle", sda_oe, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule